// File: doc/BRIEF.md
# Real-Time Clock Reload Timer Chain

This block is the counting core of a real-time clock. A single-cycle count pulse, already brought into the system clock domain, advances a 16-bit reload timer. An optional divide-by-8 prescaler can sit in front of that timer. When the timer passes its top value, it reloads from a programmable value and raises a tick request. That overflow also advances a cascaded 32-bit counter, which reloads from its own pair of 16-bit reload halves and raises an alarm request each time it overflows.

Software reaches the block through a plain word-write port and a combinational read port. Writing a counter register takes effect at once. A control word selects the prescaler, enables each interrupt source, and posts one-shot adjust requests. These requests move the 16-bit timer one count ahead of or behind its normal step at the next count event. Hardware clears each request bit once the request has been handled.

Both request flags are sticky and are cleared by a write-one strobe. The single interrupt output is high whenever an enabled flag is set.

Top module: `rtc_tick_chain`

## Requirements
- R1: With the prescaler off (control bit 0 = 0), each count pulse advances the timer (address 0) by one. With the prescaler on, only every eighth pulse does, counting from the pulse after the prescaler was switched on. With no count event and no write, the timer holds its value.
- R2: A count event that finds the timer at FFFF hex loads it from the timer reload register (address 1) and sets tick flag bit 0 in the same cycle.
- R3: Writing 1 to control bit 2 posts a decrement. The next count event then leaves the timer one lower than the normal step would.
- R4: Writing 1 to control bit 1 posts an increment. The next count event then leaves the timer one higher than the normal step (timer + 2).
- R5: A posted increment is held, and is not applied, at a count event where the timer is FFFE or FFFF hex. It is applied at the following count event.
- R6: When the timer reload value is FFFF hex, adjust requests do not change the count, and they are cleared at the next count event.
- R7: Once a request has been handled, its request bit reads back as 0 at address 6.
- R8: An increment and a decrement posted together cancel. The count takes its plain step, and both bits clear at the next count event.
- R9: Each timer overflow advances the 32-bit counter (address 2 low half, address 3 high half). If the counter is at FFFFFFFF hex, it instead loads from the reload halves (address 4 low, address 5 high) and sets alarm flag bit 1.
- R10: With all reload registers at zero, the timer and the 32-bit counter form one free-running 48-bit binary counter.
- R11: Flags are sticky and are cleared by a 1 on the matching `irq_clr` bit. `irq_o` is high when tick flag AND control bit 3, or alarm flag AND control bit 4, is set.
- R12: A register write takes effect at the next clock edge and beats a count event in the same cycle. `rd_data` shows the addressed register without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cnt_pulse | input | 1 | one-cycle count pulse from the reference clock |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | write address (0 timer, 1 timer reload, 2/3 counter low/high, 4/5 counter reload low/high, 6 control) |
| wr_data | input | 16 | write data |
| rd_addr | input | 3 | read address, same map |
| rd_data | output | 16 | read data |
| irq_clr | input | 2 | write-one-to-clear strobes for flags (bit 0 tick, bit 1 alarm) |
| irq_flag | output | 2 | sticky request flags |
| irq_o | output | 1 | combined interrupt request |

## Verification
Every count result is due one clock edge after the pulse cycle. This holds for the timer step, a reload, an applied adjust, the cascade step and the flag set, because each passes through exactly one register stage. The combined interrupt follows combinationally from the flags. The bench drives the pulse and writes on the falling edge, releases them on the next falling edge, and only then reads the read port. Each check therefore sees the state after exactly one rising edge. The held-increment case is checked over two successive pulses, so the one-event delay shows.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_TMR    = 3'd0;
  localparam logic [ADDR_W-1:0] A_TRL    = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLO    = 3'd2;
  localparam logic [ADDR_W-1:0] A_CHI    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CRLLO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CRLHI  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd6;
  localparam int B_PRE = 0;
  localparam int B_INC = 1;
  localparam int B_DEC = 2;
  localparam int B_ETK = 3;
  localparam int B_EAL = 4;
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pulse,
  output logic ev
);
  logic [DIV_LOG2-1:0] div_q;

  assign ev = en ? (pulse && (&div_q)) : pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (!en)   div_q <= '0;
    else if (pulse) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/rtc_reload_timer.sv
module rtc_reload_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic [W-1:0] rel,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic         inc_req,
  input  logic         dec_req,
  output logic [W-1:0] t,
  output logic         wrap,
  output logic         inc_done,
  output logic         dec_done
);
  localparam logic [W-1:0] TOP  = '1;
  localparam logic [W-1:0] NEAR = TOP - 1'b1;

  function automatic logic [W-1:0] step(input logic [W-1:0] cur, input logic [W-1:0] rl,
                                        input logic up, input logic down);
    logic [W-1:0] base;
    base = (cur == TOP) ? rl : cur + 1'b1;
    return base + W'(up) - W'(down);
  endfunction

  logic live, adj_ok, near, inc_apply, dec_apply;

  assign live      = ev && !wr;
  assign adj_ok    = (rel != TOP);
  assign near      = (t >= NEAR);
  assign inc_apply = live && adj_ok && inc_req && !dec_req && !near;
  assign dec_apply = live && adj_ok && dec_req && !inc_req;
  assign wrap      = live && (t == TOP);
  assign inc_done  = live && inc_req && (!near || !adj_ok || dec_req);
  assign dec_done  = live && dec_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    t <= '0;
    else if (wr)   t <= wr_val;
    else if (live) t <= step(t, rel, inc_apply, dec_apply);
  end
endmodule

// File: rtl/rtc_cascade.sv
module rtc_cascade #(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev,
  input  logic [2*HW-1:0] rel,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HW-1:0]   wr_val,
  output logic [2*HW-1:0] cnt,
  output logic            ovf
);
  localparam int W = 2 * HW;

  function automatic logic [W-1:0] advance(input logic [W-1:0] cur, input logic [W-1:0] rl);
    return (cur == '1) ? rl : cur + 1'b1;
  endfunction

  logic live;
  assign live = ev && !wr_lo && !wr_hi;
  assign ovf  = live && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt[HW-1:0] <= wr_val;
      if (wr_hi) cnt[W-1:HW] <= wr_val;
    end
    else if (live) cnt <= advance(cnt, rel);
  end
endmodule

// File: rtl/rtc_tick_chain.sv
module rtc_tick_chain
  import rtc_pkg::*;
#(
  parameter int T_W      = 16,
  parameter int DIV_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_pulse,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [T_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [T_W-1:0]    rd_data,
  input  logic [1:0]        irq_clr,
  output logic [1:0]        irq_flag,
  output logic              irq_o
);
  localparam int C_W = 2 * T_W;

  logic [T_W-1:0] rel16, rel_lo, rel_hi, t16;
  logic [C_W-1:0] cnt32;
  logic pre_en, inc_q, dec_q, en_tick, en_alarm;
  logic ev16, wrap16, ovf32, inc_done, dec_done;
  logic wr_t16, wr_clo, wr_chi, wr_ctrl;

  assign wr_t16  = wr_en && (wr_addr == A_TMR);
  assign wr_clo  = wr_en && (wr_addr == A_CLO);
  assign wr_chi  = wr_en && (wr_addr == A_CHI);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

  rtc_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(pre_en), .pulse(cnt_pulse), .ev(ev16)
  );

  rtc_reload_timer #(.W(T_W)) u_t16 (
    .clk(clk), .rst_n(rst_n), .ev(ev16), .rel(rel16),
    .wr(wr_t16), .wr_val(wr_data), .inc_req(inc_q), .dec_req(dec_q),
    .t(t16), .wrap(wrap16), .inc_done(inc_done), .dec_done(dec_done)
  );

  rtc_cascade #(.HW(T_W)) u_c32 (
    .clk(clk), .rst_n(rst_n), .ev(wrap16), .rel({rel_hi, rel_lo}),
    .wr_lo(wr_clo), .wr_hi(wr_chi), .wr_val(wr_data),
    .cnt(cnt32), .ovf(ovf32)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel16 <= '0; rel_lo <= '0; rel_hi <= '0;
      pre_en <= 1'b0; en_tick <= 1'b0; en_alarm <= 1'b0;
      inc_q <= 1'b0; dec_q <= 1'b0;
      irq_flag <= '0;
    end else begin
      if (wr_en && wr_addr == A_TRL)   rel16  <= wr_data;
      if (wr_en && wr_addr == A_CRLLO) rel_lo <= wr_data;
      if (wr_en && wr_addr == A_CRLHI) rel_hi <= wr_data;
      if (wr_ctrl) begin
        pre_en   <= wr_data[B_PRE];
        en_tick  <= wr_data[B_ETK];
        en_alarm <= wr_data[B_EAL];
      end
      if (wr_ctrl && wr_data[B_INC]) inc_q <= 1'b1;
      else if (inc_done)             inc_q <= 1'b0;
      if (wr_ctrl && wr_data[B_DEC]) dec_q <= 1'b1;
      else if (dec_done)             dec_q <= 1'b0;
      irq_flag <= (irq_flag & ~irq_clr) | {ovf32, wrap16};
    end
  end

  assign irq_o = (irq_flag[0] && en_tick) || (irq_flag[1] && en_alarm);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_TMR:   rd_data = t16;
      A_TRL:   rd_data = rel16;
      A_CLO:   rd_data = cnt32[T_W-1:0];
      A_CHI:   rd_data = cnt32[C_W-1:T_W];
      A_CRLLO: rd_data = rel_lo;
      A_CRLHI: rd_data = rel_hi;
      A_CTRL: begin
        rd_data[B_PRE] = pre_en;
        rd_data[B_INC] = inc_q;
        rd_data[B_DEC] = dec_q;
        rd_data[B_ETK] = en_tick;
        rd_data[B_EAL] = en_alarm;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtc_tick_chain_chk.sv
module rtc_tick_chain_chk #(
  parameter int T_W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ev16,
  input logic           wrap16,
  input logic           wr_t16,
  input logic           wr_clo,
  input logic           wr_chi,
  input logic           wr_ctrl,
  input logic           dec_q,
  input logic [T_W-1:0] t16,
  input logic [T_W-1:0] rel16,
  input logic [2*T_W-1:0] cnt32,
  input logic [1:0]     irq_flag,
  input logic           irq_o
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ev16 && !wr_t16 |=> $stable(t16));

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev16 && !wr_t16 && (t16 == '1) && !dec_q |=> t16 == $past(rel16));

  p_tick_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap16 |=> irq_flag[0]);

  p_dec_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev16 && !wr_t16 && dec_q && !wr_ctrl |=> !dec_q);

  p_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap16 && !wr_clo && !wr_chi |=> $stable(cnt32));

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_flag != 2'b00));
endmodule

bind rtc_tick_chain rtc_tick_chain_chk #(.T_W(T_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev16(ev16), .wrap16(wrap16),
  .wr_t16(wr_t16), .wr_clo(wr_clo), .wr_chi(wr_chi), .wr_ctrl(wr_ctrl),
  .dec_q(dec_q), .t16(t16), .rel16(rel16), .cnt32(cnt32),
  .irq_flag(irq_flag), .irq_o(irq_o)
);

// File: tb/test_rtc_tick_chain.sv
module test_rtc_tick_chain;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_pulse = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  irq_clr = '0;
  logic [1:0]  irq_flag;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_tick_chain i_rtc_tick_chain (
    .clk(clk), .rst_n(rst_n), .cnt_pulse(cnt_pulse),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_clr(irq_clr), .irq_flag(irq_flag), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_pulse = 1'b1;
      @(negedge clk);
      cnt_pulse = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    irq_clr = 2'b11;
    @(negedge clk);
    irq_clr = 2'b00;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R12 reset value", v, 0);
    end
    check("R11 reset irq", {irq_flag, irq_o}, 0);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    wr(3'd6, 16'h0000);
    wr(3'd0, 16'h0000);
    pulse(3);
    rd(3'd0, v); check("R1 direct count", v, 16'h0003);
    wr(3'd6, 16'h0001);
    pulse(7);
    rd(3'd0, v); check("R1 prescaled hold 7", v, 16'h0003);
    pulse(1);
    rd(3'd0, v); check("R1 prescaled 8th", v, 16'h0004);
    wr(3'd6, 16'h0000);
  endtask

  task automatic t_reload();
    logic [15:0] v;
    wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);
    wr(3'd1, 16'h1234);
    wr(3'd0, 16'hFFFF);
    clear_flags();
    pulse(1);
    rd(3'd0, v); check("R2 reload value", v, 16'h1234);
    check("R2 tick flag", irq_flag[0], 1'b1);
    rd(3'd2, v); check("R9 cascade step", v, 16'h0001);
    clear_flags();
  endtask

  task automatic t_dec();
    logic [15:0] v;
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0100);
    wr(3'd6, 16'h0004);
    pulse(1);
    rd(3'd0, v); check("R3 decrement", v, 16'h0100);
    rd(3'd6, v); check("R7 dec bit cleared", v[2], 1'b0);
  endtask

  task automatic t_inc();
    logic [15:0] v;
    wr(3'd6, 16'h0002);
    pulse(1);
    rd(3'd0, v); check("R4 increment", v, 16'h0102);
    rd(3'd6, v); check("R7 inc bit cleared", v[1], 1'b0);
  endtask

  task automatic t_inc_held();
    logic [15:0] v;
    wr(3'd1, 16'h0010);
    wr(3'd0, 16'hFFFF);
    wr(3'd6, 16'h0002);
    pulse(1);
    rd(3'd0, v); check("R5 held at reload", v, 16'h0010);
    rd(3'd6, v); check("R5 inc still pending", v[1], 1'b1);
    pulse(1);
    rd(3'd0, v); check("R5 applied next event", v, 16'h0012);
    rd(3'd6, v); check("R7 inc cleared after hold", v[1], 1'b0);
    clear_flags();
  endtask

  task automatic t_rel_top();
    logic [15:0] v;
    wr(3'd1, 16'hFFFF);
    wr(3'd0, 16'h0050);
    wr(3'd6, 16'h0002);
    pulse(1);
    rd(3'd0, v); check("R6 inc ignored", v, 16'h0051);
    rd(3'd6, v); check("R6 inc cleared", v[2:1], 2'b00);
    wr(3'd6, 16'h0004);
    pulse(1);
    rd(3'd0, v); check("R6 dec ignored", v, 16'h0052);
    rd(3'd6, v); check("R6 dec cleared", v[2:1], 2'b00);
  endtask

  task automatic t_both();
    logic [15:0] v;
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0060);
    wr(3'd6, 16'h0006);
    pulse(1);
    rd(3'd0, v); check("R8 cancel step", v, 16'h0061);
    rd(3'd6, v); check("R8 both cleared", v[2:1], 2'b00);
  endtask

  task automatic t_cascade();
    logic [15:0] v;
    clear_flags();
    wr(3'd4, 16'h0005); wr(3'd5, 16'h0007);
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF);
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'hFFFF);
    pulse(1);
    rd(3'd0, v); check("R9 timer wrapped", v, 16'h0000);
    rd(3'd2, v); check("R9 reload low", v, 16'h0005);
    rd(3'd3, v); check("R9 reload high", v, 16'h0007);
    check("R9 alarm flag", irq_flag, 2'b11);
    clear_flags();
  endtask

  task automatic t_48();
    logic [15:0] v;
    wr(3'd4, 16'h0000); wr(3'd5, 16'h0000);
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'h0000);
    wr(3'd0, 16'hFFFE);
    pulse(1);
    rd(3'd0, v); check("R10 low word", v, 16'hFFFF);
    pulse(1);
    rd(3'd0, v); check("R10 carry bits 15:0", v, 16'h0000);
    rd(3'd2, v); check("R10 carry bits 31:16", v, 16'h0000);
    rd(3'd3, v); check("R10 carry bits 47:32", v, 16'h0001);
    clear_flags();
  endtask

  task automatic t_irq();
    wr(3'd6, 16'h0000);
    wr(3'd0, 16'hFFFF);
    pulse(1);
    check("R11 flag set while masked", irq_flag[0], 1'b1);
    check("R11 masked output", irq_o, 1'b0);
    wr(3'd6, 16'h0008);
    check("R11 enabled output", irq_o, 1'b1);
    clear_flags();
    check("R11 cleared flags", irq_flag, 2'b00);
    check("R11 cleared output", irq_o, 1'b0);
    wr(3'd6, 16'h0000);
  endtask

  task automatic t_write_wins();
    logic [15:0] v;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0020; cnt_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_pulse = 1'b0;
    rd(3'd0, v); check("R12 write beats count", v, 16'h0020);
    wr(3'd1, 16'hABCD);
    rd(3'd1, v); check("R12 readback", v, 16'hABCD);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prescale();
        t_reload();
        t_dec();
        t_inc();
        t_inc_held();
        t_rel_top();
        t_both();
        t_cascade();
        t_48();
        t_irq();
        t_write_wins();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule